// File: doc/BRIEF.md
# Serial ADC Conversion-and-Read Controller

This block drives one 12-bit successive-approximation converter through its three-wire serial port. On an accepted request it selects the converter, keeping the serial clock low while the converter works. It then waits for the end of conversion. In edge mode that is the first rise of the converter's data line. A cycle-count timeout always stands behind it as a fallback, and it is the only trigger when edge mode is off. The block then issues a frame of serial clocks with idle-low polarity and samples the data line on every rising edge. After the frame it deselects the converter and keeps it deselected for a minimum gap before the next conversion may start.

A frame is either the short form of 13 clocks (the marker bit plus 12 data bits) or the byte form of 16 clocks, where the three trailing zero bits are dropped. The first bit sampled must be the converter's high marker bit. If it is, the 12-bit result goes out on a valid/ready stream. If it is not, a one-cycle error pulse is raised instead. All timing is set in system clock cycles through parameters. After reset, a startup wait must pass before the first request is taken.

Stream rules: `req_valid`/`req_ready` form the request handshake, and a request is taken on a clock edge where both are high. `res_valid` stays high, with `res_data` unchanged, until a cycle in which `res_ready` is high. While a result is still held, `req_ready` stays low, so a consumer that is not ready stalls further conversions.

Top module: `adc_rd_ctrl`

## Requirements
- R1: After reset `adc_sel_n` is high, `adc_sck` low, `res_valid` low and `busy` high. No conversion starts until at least STARTUP_CYC cycles after reset release.
- R2: `req_ready` is high only when the block is idle and no result is pending. An accepted request drives `adc_sel_n` low in the next cycle, and `adc_sck` is low whenever `adc_sel_n` is high.
- R3: After `adc_sel_n` falls, `adc_sck` stays low until end of conversion. With `eoc_edge_en`=1, end of conversion is a 0-to-1 change of `adc_sdo`. In both modes it is also reached after CONV_TMO cycles, and with `eoc_edge_en`=0 that timeout is the only trigger.
- R4: Every high phase and every low phase of `adc_sck` within a frame lasts at least SCK_HALF_CYC cycles.
- R5: With `byte_mode`=0 a frame has exactly 13 rising edges of `adc_sck`; with `byte_mode`=1 it has 16. `adc_sel_n` rises at or after the last falling edge.
- R6: The data line is sampled on rising `adc_sck` edges. `res_data` holds the 12 bits sampled after the marker, first sampled in bit 11. In byte mode the last three samples are dropped.
- R7: If the first sampled bit is 0, `err_flag` pulses high for exactly one cycle and `res_valid` stays low for that frame.
- R8: After `adc_sel_n` rises it stays high for at least DESEL_CYC cycles.
- R9: `res_valid` with `res_data` unchanged holds until a cycle with `res_ready` high, after which `res_valid` falls. While `res_valid` is high, `req_ready` is low.
- R10: `busy` is high during startup and from the selection of the converter to the end of the deselect gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Conversion request |
| req_ready | output | 1 | Request can be taken |
| eoc_edge_en | input | 1 | 1: end conversion on data rise (timeout as fallback) |
| byte_mode | input | 1 | 0: 13-clock frame, 1: 16-clock frame |
| adc_sdo | input | 1 | Converter serial data line |
| adc_sel_n | output | 1 | Converter select, active low |
| adc_sck | output | 1 | Serial clock, idle low |
| res_data | output | 12 | Conversion result |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result accepted |
| err_flag | output | 1 | One-cycle pulse on a missing marker bit |
| busy | output | 1 | Startup, conversion, read or deselect in progress |

## Verification
The bench builds the block with SCK_HALF_CYC=6, CONV_TMO=80, DESEL_CYC=10 and STARTUP_CYC=50 instead of the physical defaults. This keeps each frame to a few hundred cycles, so dozens of conversions with both frame lengths and both end-of-conversion modes fit in a short run. The converter model's latency is kept below the timeout, which makes the edge-triggered start measurably earlier than the timeout start. Dropping the marker bit exercises the timeout fallback and the error path.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_IDLE,
    ST_CONV,
    ST_SHIFT,
    ST_DESEL
  } rd_state_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/adc_rd_sync.sv
module adc_rd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= W'(RST_VAL);
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - W'(1);
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/adc_rd_sck_gen.sv
module adc_rd_sck_gen #(
  parameter int HALF = 40,
  parameter int EW   = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [EW-1:0] n_edges,
  output logic          sck,
  output logic          rise,
  output logic          done
);
  localparam int PW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [PW-1:0] ph;
  logic [EW-1:0] falls;
  logic [EW-1:0] falls_nx;

  assign falls_nx = falls + EW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= '0;
      falls <= '0;
      sck   <= 1'b0;
      rise  <= 1'b0;
      done  <= 1'b0;
    end else if (!run) begin
      ph    <= '0;
      falls <= '0;
      sck   <= 1'b0;
      rise  <= 1'b0;
      done  <= 1'b0;
    end else begin
      rise <= 1'b0;
      done <= 1'b0;
      if (ph == PW'(HALF - 1)) begin
        ph  <= '0;
        sck <= ~sck;
        if (!sck) begin
          rise <= 1'b1;
        end else begin
          falls <= falls_nx;
          if (falls_nx == n_edges) done <= 1'b1;
        end
      end else begin
        ph <= ph + PW'(1);
      end
    end
  end
endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture #(
  parameter int DW = 12,
  parameter int FB = 16,
  parameter int EW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          shift_en,
  input  logic          bit_in,
  input  logic [EW-1:0] n_bits,
  output logic [DW-1:0] word,
  output logic          marker
);
  localparam int FMIN = DW + 1;

  logic [FB-1:0] sr;
  logic [FB-1:0] aligned;
  logic [EW-1:0] drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr <= '0;
    else if (clr)      sr <= '0;
    else if (shift_en) sr <= {sr[FB-2:0], bit_in};
  end

  assign drop    = n_bits - EW'(FMIN);
  assign aligned = sr >> drop;
  assign word    = aligned[DW-1:0];
  assign marker  = aligned[DW];
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl #(
  parameter int DW           = 12,
  parameter int SCK_HALF_CYC = 40,
  parameter int CONV_TMO     = 1500,
  parameter int DESEL_CYC    = 48,
  parameter int STARTUP_CYC  = 2000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          eoc_edge_en,
  input  logic          byte_mode,
  input  logic          adc_sdo,
  output logic          adc_sel_n,
  output logic          adc_sck,
  output logic [DW-1:0] res_data,
  output logic          res_valid,
  input  logic          res_ready,
  output logic          err_flag,
  output logic          busy
);
  import adc_rd_pkg::*;

  localparam int FRAME_MIN  = DW + 1;
  localparam int FRAME_BYTE = ((DW + 1 + 7) / 8) * 8;
  localparam int EW         = $clog2(FRAME_BYTE + 1);
  localparam int TMAX       = max3(CONV_TMO, DESEL_CYC, STARTUP_CYC);
  localparam int TW         = $clog2(TMAX + 1);

  rd_state_t     state;
  logic          sel_n_q;
  logic          byte_q;
  logic          edge_q;
  logic          valid_q;
  logic [DW-1:0] data_q;
  logic          err_q;

  logic          sdo_s;
  logic          sdo_prev;
  logic          sdo_rise;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_exp;
  logic          sck_run;
  logic          sck_rise;
  logic          sck_done;
  logic [EW-1:0] n_edges;
  logic [DW-1:0] cap_word;
  logic          cap_marker;
  logic          accept;
  logic          conv_end;

  adc_rd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(adc_sdo), .q(sdo_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sdo_prev <= 1'b0;
    else        sdo_prev <= sdo_s;
  end
  assign sdo_rise = sdo_s & ~sdo_prev;

  assign accept   = (state == ST_IDLE) && !valid_q && req_valid;
  assign conv_end = (state == ST_CONV) && ((edge_q && sdo_rise) || tmr_exp);
  assign sck_run  = (state == ST_SHIFT);
  assign n_edges  = byte_q ? EW'(FRAME_BYTE) : EW'(FRAME_MIN);

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (accept) begin
      tmr_load = 1'b1;
      tmr_val  = TW'(CONV_TMO);
    end else if (sck_run && sck_done) begin
      tmr_load = 1'b1;
      tmr_val  = TW'(DESEL_CYC);
    end
  end

  adc_rd_timer #(.W(TW), .RST_VAL(STARTUP_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_exp)
  );

  adc_rd_sck_gen #(.HALF(SCK_HALF_CYC), .EW(EW)) u_sck (
    .clk(clk), .rst_n(rst_n), .run(sck_run), .n_edges(n_edges),
    .sck(adc_sck), .rise(sck_rise), .done(sck_done)
  );

  adc_rd_capture #(.DW(DW), .FB(FRAME_BYTE), .EW(EW)) u_cap (
    .clk(clk), .rst_n(rst_n), .clr(accept), .shift_en(sck_rise),
    .bit_in(sdo_s), .n_bits(n_edges), .word(cap_word), .marker(cap_marker)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_BOOT;
      sel_n_q <= 1'b1;
      byte_q  <= 1'b0;
      edge_q  <= 1'b0;
      valid_q <= 1'b0;
      data_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (valid_q && res_ready) valid_q <= 1'b0;
      unique case (state)
        ST_BOOT: if (tmr_exp) state <= ST_IDLE;
        ST_IDLE: if (accept) begin
          state   <= ST_CONV;
          sel_n_q <= 1'b0;
          byte_q  <= byte_mode;
          edge_q  <= eoc_edge_en;
        end
        ST_CONV: if (conv_end) state <= ST_SHIFT;
        ST_SHIFT: if (sck_done) begin
          state   <= ST_DESEL;
          sel_n_q <= 1'b1;
          if (cap_marker) begin
            valid_q <= 1'b1;
            data_q  <= cap_word;
          end else begin
            err_q <= 1'b1;
          end
        end
        ST_DESEL: if (tmr_exp) state <= ST_IDLE;
        default: state <= ST_BOOT;
      endcase
    end
  end

  assign adc_sel_n = sel_n_q;
  assign res_valid = valid_q;
  assign res_data  = data_q;
  assign err_flag  = err_q;
  assign busy      = (state != ST_IDLE);
  assign req_ready = (state == ST_IDLE) && !valid_q;
endmodule

// File: rtl/adc_rd_ctrl_chk.sv
module adc_rd_ctrl_chk #(
  parameter int DW           = 12,
  parameter int SCK_HALF_CYC = 40,
  parameter int DESEL_CYC    = 48
) (
  input logic          clk,
  input logic          rst_n,
  input logic          adc_sel_n,
  input logic          adc_sck,
  input logic          req_ready,
  input logic          res_valid,
  input logic          res_ready,
  input logic [DW-1:0] res_data,
  input logic          err_flag,
  input logic          busy
);
  localparam int CMAX = (SCK_HALF_CYC > DESEL_CYC ? SCK_HALF_CYC : DESEL_CYC) + 2;
  localparam int CW   = $clog2(CMAX + 1);

  logic          sck_d;
  logic [CW-1:0] run_cnt;
  logic [CW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d   <= 1'b0;
      run_cnt <= CW'(CMAX);
      hi_cnt  <= CW'(CMAX);
    end else begin
      sck_d <= adc_sck;
      if (adc_sck != sck_d)         run_cnt <= CW'(1);
      else if (run_cnt != CW'(CMAX)) run_cnt <= run_cnt + CW'(1);
      if (!adc_sel_n)               hi_cnt <= '0;
      else if (hi_cnt != CW'(CMAX)) hi_cnt <= hi_cnt + CW'(1);
    end
  end

  // R4
  sck_phase_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_sck != sck_d) |-> (run_cnt >= CW'(SCK_HALF_CYC)));

  // R8
  desel_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_sel_n) |-> (hi_cnt >= CW'(DESEL_CYC)));

  // R2
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_sel_n |-> !adc_sck);

  // R2
  req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (adc_sel_n && !res_valid));

  // R9
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  // R7
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> !err_flag);

  // R10
  busy_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_sel_n |-> busy);
endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk #(
  .DW(DW), .SCK_HALF_CYC(SCK_HALF_CYC), .DESEL_CYC(DESEL_CYC)
) u_chk (.*);

// File: tb/adc_rd_ctrl_bench.sv
module adc_rd_ctrl_bench;
  localparam int HALF    = 6;
  localparam int TMO     = 80;
  localparam int DESEL   = 10;
  localparam int STARTUP = 50;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        eoc_edge_en = 1'b1;
  logic        byte_mode = 1'b0;
  logic        adc_sdo = 1'b0;
  logic        adc_sel_n;
  logic        adc_sck;
  logic [11:0] res_data;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic        err_flag;
  logic        busy;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int last_hi = -1;
  bit finished = 1'b0;

  logic [11:0] m_word = '0;
  int          m_lat = 10;
  bit          m_kill = 1'b0;
  int          m_idx = 0;

  always #2.5 clk = ~clk;

  adc_rd_ctrl #(
    .DW(12), .SCK_HALF_CYC(HALF), .CONV_TMO(TMO), .DESEL_CYC(DESEL),
    .STARTUP_CYC(STARTUP), .SYNC_STAGES(2)
  ) u_adc_rd_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .eoc_edge_en(eoc_edge_en), .byte_mode(byte_mode), .adc_sdo(adc_sdo),
    .adc_sel_n(adc_sel_n), .adc_sck(adc_sck), .res_data(res_data),
    .res_valid(res_valid), .res_ready(res_ready), .err_flag(err_flag),
    .busy(busy)
  );

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // converter port model
  initial forever begin
    @(negedge adc_sel_n);
    m_idx   = 0;
    adc_sdo = 1'b0;
    if (!m_kill) begin
      repeat (m_lat) @(posedge clk);
      if (!adc_sel_n) adc_sdo = 1'b1;
    end
  end
  always @(negedge adc_sck) if (!adc_sel_n) begin
    adc_sdo = (m_idx < 12) ? m_word[11 - m_idx] : 1'b0;
    m_idx++;
  end
  always @(posedge adc_sel_n) adc_sdo = 1'b0;

  function automatic int exp_edges(input bit bm);
    return bm ? 16 : 13;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic txn(input logic [11:0] w, input int lat, input bit een,
                     input bit bm, input bit kill);
    int t0, rises, first, run, minrun;
    logic prev;
    m_word = w; m_lat = lat; m_kill = kill;
    eoc_edge_en = een; byte_mode = bm;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(adc_sel_n == 1'b0, "R2 select after accept", adc_sel_n, 0);
    chk(busy == 1'b1, "R10 busy while selected", busy, 1);
    t0 = cyc;
    if (last_hi >= 0) chk(t0 - last_hi >= DESEL, "R8 deselect gap", t0 - last_hi, DESEL);
    rises = 0; first = -1; prev = adc_sck; run = 0; minrun = 1000;
    while (!adc_sel_n) begin
      if (adc_sck != prev) begin
        if (first >= 0 && run < minrun) minrun = run;
        if (adc_sck) begin
          rises++;
          if (first < 0) first = cyc - t0;
        end
        run = 0;
      end
      run++;
      prev = adc_sck;
      @(negedge clk);
    end
    last_hi = cyc;
    chk(rises == exp_edges(bm), "R5 edge count", rises, exp_edges(bm));
    chk(minrun >= HALF, "R4 phase width", minrun, HALF);
    if (een && !kill)
      chk(first > lat && first < TMO, "R3 edge start", first, lat);
    else
      chk(first >= TMO, "R3 timeout start", first, TMO);
    if (kill) begin
      chk(err_flag == 1'b1 && res_valid == 1'b0, "R7 marker error", {err_flag, res_valid}, 2);
      @(negedge clk);
      chk(err_flag == 1'b0 && res_valid == 1'b0, "R7 single pulse", {err_flag, res_valid}, 0);
    end else begin
      chk(res_valid == 1'b1, "R6 valid", res_valid, 1);
      chk(res_data == w, "R6 data", res_data, w);
      repeat (3) @(negedge clk);
      chk(res_valid && res_data == w && !req_ready, "R9 hold", {res_valid, req_ready}, 2);
      res_ready = 1'b1;
      @(negedge clk);
      res_ready = 1'b0;
      chk(res_valid == 1'b0, "R9 release", res_valid, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      finish_run();
    end
  end

  initial begin
    int tfall;
    void'($urandom(32'h5a17));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(adc_sel_n == 1'b1 && adc_sck == 1'b0 && res_valid == 1'b0 && busy == 1'b1,
        "R1 reset state", {adc_sel_n, adc_sck, res_valid, busy}, 9);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b0 && busy == 1'b1, "R10 busy in startup", {req_ready, busy}, 1);
    m_word = 12'h5A3; m_lat = 12; m_kill = 1'b0;
    req_valid = 1'b1;
    while (adc_sel_n) @(negedge clk);
    tfall = cyc;
    req_valid = 1'b0;
    chk(tfall >= STARTUP, "R1 startup wait", tfall, STARTUP);
    while (!adc_sel_n) @(negedge clk);
    last_hi = cyc;
    chk(res_valid && res_data == 12'h5A3, "R6 first word", res_data, 12'h5A3);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    // directed corners
    txn(12'h000, 8, 1'b1, 1'b0, 1'b0);
    txn(12'hFFF, 8, 1'b1, 1'b1, 1'b0);
    txn(12'h800, 30, 1'b0, 1'b0, 1'b0);
    txn(12'h001, 30, 1'b0, 1'b1, 1'b0);
    txn(12'hABC, 10, 1'b1, 1'b0, 1'b1);
    txn(12'h3C5, 10, 1'b0, 1'b1, 1'b1);
    txn(12'h7FE, 45, 1'b1, 1'b1, 1'b0);
    // random mix
    for (int i = 0; i < 30; i++) begin
      txn(12'($urandom), 5 + int'($urandom % 40), 1'($urandom), 1'($urandom),
          ($urandom % 8) == 0);
    end
    finished = 1'b1;
    finish_run();
  end
endmodule